// File: doc/BRIEF.md
# Framed Synchronous Serial Codec Port

This block is the digital serial port on the converter side of a six-channel sigma-delta codec. It connects to a host signal processor over a framed synchronous link. The port drives a serial clock that it divides down from its own clock. It shifts out one 16-bit word per channel on a single data line. It also accepts 16-bit words on a data input. Each direction has its own one-bit frame sync. The outbound sync is launched on the rising serial-clock edge. The inbound sync is sampled on the falling edge.

A sample tick starts an outbound frame. The frame carries the six channel holding registers in ascending order. Each word is announced by a sync pulse that occupies the bit period just before its MSB. Received words appear on a parallel output together with a one-cycle strobe. A port-enable input does three things when it is low:

- it releases the output pads;
- it blinds the receiver;
- it parks the serial clock.

Dropping port enable restarts every timing counter. It leaves the holding registers untouched, so the link resumes with its old configuration when the enable returns.

Top module: `fsync_codec_port`

## Requirements
- R1: The serial clock has a period of 2*M*S clk cycles, high for M*S and low for M*S. M is the low 4 bits of the register at address 6 and S is the low 4 bits of the register at address 7. A stored value of 0 behaves as 1.
- R2: While the port stays enabled, sdo and ofs change only in the clk cycle in which sclk goes high.
- R3: Each sample tick produces one frame. A frame is the words at addresses 0 to 5, sent in ascending address order, each as 16 bits MSB first. sdo_oe is high only while those 16 data bits are on the line.
- R4: ofs is high for exactly one serial-clock period, the one directly before each word's MSB, and sdo_oe is low during that period.
- R5: While port_en is low, sdo_oe and ofs_oe are low, sclk stays low, and sdi and ifs have no effect: rx_valid stays low.
- R6: Dropping port_en keeps the channel words, both dividers and rx_word. It aborts any frame in progress and restarts the clock divider. After re-enable a new tick yields a complete frame at the retained rate.
- R7: When ifs is sampled high on a falling sclk edge, the next 16 falling edges sample sdi MSB first. rx_word takes the word and rx_valid pulses for one clk cycle, in the cycle in which sclk goes low after the LSB is sampled.
- R8: The asynchronous active-low reset clears all holding registers, rx_word and all timing state. sclk, sdo_oe and rx_valid read low.
- R9: A sample tick that arrives while a frame is running is held, and one further complete frame follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, source of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low releases pads, parks clock, restarts timing |
| sample_tick | input | 1 | One-cycle request to send a frame |
| cfg_we | input | 1 | Holding register write strobe |
| cfg_addr | input | 3 | Register address: 0-5 channel words, 6 M divider, 7 S divider |
| cfg_wdata | input | 16 | Register write data |
| sdi | input | 1 | Serial data in |
| ifs | input | 1 | Inbound frame sync |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Pad enable for sdo |
| ofs | output | 1 | Outbound frame sync |
| ofs_oe | output | 1 | Pad enable for ofs |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |

## Verification
The bound checker enforces the following on every cycle:

- sdo and ofs move only on a rising serial-clock edge;
- the sync slot never overlaps driven data;
- the clock is parked one cycle after the enable falls;
- the receive strobe is a single cycle aligned with a falling edge.

Some behaviour only the bench scenarios can show: channel order, bit order, the divider product, a queued second frame, and register retention across a disable and re-enable. The bench models the host processor and compares whole words against a scoreboard for these.

// File: rtl/fcp_pkg.sv
package fcp_pkg;

   // one-cycle strobes marking the clk edge at which sclk changes level
   typedef struct packed {
      logic rise;
      logic fall;
   } sclk_evt_t;

endpackage

// File: rtl/fcp_regs.sv
module fcp_regs #(
   parameter int NCH    = 6,
   parameter int WORD_W = 16,
   parameter int DIV_W  = 4,
   parameter int ADDR_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [WORD_W-1:0]             wdata,
   output logic [NCH-1:0][WORD_W-1:0]    chan_words,
   output logic [DIV_W-1:0]              mdiv,
   output logic [DIV_W-1:0]              sdiv
);

   localparam logic [ADDR_W-1:0] M_ADDR = ADDR_W'(NCH);
   localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(NCH + 1);

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chan_words[g] <= '0;
         else if (we && addr == ADDR_W'(g))
            chan_words[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdiv <= '0;
         sdiv <= '0;
      end else if (we) begin
         if (addr == M_ADDR) mdiv <= wdata[DIV_W-1:0];
         if (addr == S_ADDR) sdiv <= wdata[DIV_W-1:0];
      end
   end

endmodule

// File: rtl/fcp_clkgen.sv
module fcp_clkgen
   import fcp_pkg::*;
#(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] mdiv,
   input  logic [DIV_W-1:0] sdiv,
   output logic             sclk,
   output sclk_evt_t        evt
);

   localparam int CNT_W = 2 * DIV_W;

   logic [DIV_W-1:0] m_eff, s_eff;
   logic [CNT_W-1:0] half, cnt;
   logic             tick;

   always_comb begin
      m_eff = (mdiv == '0) ? DIV_W'(1) : mdiv;
      s_eff = (sdiv == '0) ? DIV_W'(1) : sdiv;
      half  = CNT_W'(m_eff) * CNT_W'(s_eff);
      // >= keeps the counter safe when a smaller divider is written mid-phase
      tick  = en && (cnt >= half - CNT_W'(1));
      evt.rise = tick & ~sclk;
      evt.fall = tick &  sclk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         sclk <= 1'b0;
      end else if (tick) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/fcp_tx.sv
module fcp_tx #(
   parameter int NCH    = 6,
   parameter int WORD_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic                       rise,
   input  logic                       sample_tick,
   input  logic [NCH-1:0][WORD_W-1:0] chan_words,
   output logic                       sdo,
   output logic                       drv,
   output logic                       ofs
);

   localparam int SLOT_W = $clog2(WORD_W + 1);
   localparam int CH_W   = $clog2(NCH);

   logic              busy, pend, start;
   logic [SLOT_W-1:0] slot;   // 0: sync period, k: data bit WORD_W-k on the line
   logic [CH_W-1:0]   chan;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] cur_word;

   always_comb begin
      start    = rise && !busy && pend;
      cur_word = chan_words[chan];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !en) begin
         busy  <= 1'b0;
         pend  <= 1'b0;
         slot  <= '0;
         chan  <= '0;
         shreg <= '0;
         sdo   <= 1'b0;
         drv   <= 1'b0;
         ofs   <= 1'b0;
      end else begin
         pend <= (pend && !start) || sample_tick;
         if (rise) begin
            if (!busy) begin
               drv <= 1'b0;
               if (pend) begin
                  busy <= 1'b1;
                  chan <= '0;
                  slot <= '0;
                  ofs  <= 1'b1;
               end else begin
                  ofs  <= 1'b0;
               end
            end else if (slot == '0) begin
               sdo   <= cur_word[WORD_W-1];
               shreg <= {cur_word[WORD_W-2:0], 1'b0};
               drv   <= 1'b1;
               ofs   <= 1'b0;
               slot  <= SLOT_W'(1);
            end else if (slot < SLOT_W'(WORD_W)) begin
               sdo   <= shreg[WORD_W-1];
               shreg <= {shreg[WORD_W-2:0], 1'b0};
               slot  <= slot + SLOT_W'(1);
            end else begin
               drv <= 1'b0;
               if (chan == CH_W'(NCH - 1)) begin
                  busy <= 1'b0;
               end else begin
                  chan <= chan + CH_W'(1);
                  slot <= '0;
                  ofs  <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/fcp_rx.sv
module fcp_rx #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fall,
   input  logic              sdi,
   input  logic              ifs,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);

   localparam int CNT_W = $clog2(WORD_W);

   logic              active, last_bit;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-2:0] sh;

   assign last_bit = active && (cnt == CNT_W'(WORD_W - 1));

   // timing state: cleared by reset and by a disabled port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !en) begin
         active   <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (fall) begin
            if (active) begin
               sh <= {sh[WORD_W-3:0], sdi};
               if (last_bit) begin
                  active   <= 1'b0;
                  rx_valid <= 1'b1;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end else if (ifs) begin
               active <= 1'b1;
               cnt    <= '0;
            end
         end
      end
   end

   // data register: only reset clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_word <= '0;
      else if (en && fall && last_bit)
         rx_word <= {sh, sdi};
   end

endmodule

// File: rtl/fsync_codec_port.sv
module fsync_codec_port
   import fcp_pkg::*;
#(
   parameter  int NCH    = 6,
   parameter  int WORD_W = 16,
   parameter  int DIV_W  = 4,
   localparam int ADDR_W = $clog2(NCH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              sample_tick,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              sdi,
   input  logic              ifs,
   output logic              sclk,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              ofs,
   output logic              ofs_oe,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);

   if (NCH < 2) begin : g_bad_nch
      $error("NCH must be at least 2");
   end
   if (WORD_W < 4) begin : g_bad_word
      $error("WORD_W must be at least 4");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end

   logic [NCH-1:0][WORD_W-1:0] chan_words;
   logic [DIV_W-1:0]           mdiv, sdiv;
   sclk_evt_t                  evt;
   logic                       tx_drv;

   fcp_regs #(.NCH(NCH), .WORD_W(WORD_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .chan_words(chan_words), .mdiv(mdiv), .sdiv(sdiv)
   );

   fcp_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .en(port_en), .mdiv(mdiv), .sdiv(sdiv),
      .sclk(sclk), .evt(evt)
   );

   fcp_tx #(.NCH(NCH), .WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(port_en), .rise(evt.rise),
      .sample_tick(sample_tick), .chan_words(chan_words),
      .sdo(sdo), .drv(tx_drv), .ofs(ofs)
   );

   fcp_rx #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(port_en), .fall(evt.fall),
      .sdi(sdi), .ifs(ifs), .rx_word(rx_word), .rx_valid(rx_valid)
   );

   // pad enables drop at once with the enable pin, ahead of the registered state
   assign sdo_oe = port_en & tx_drv;
   assign ofs_oe = port_en;

endmodule

// File: rtl/fcp_chk.sv
module fcp_chk (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic sclk,
   input logic sdo,
   input logic sdo_oe,
   input logic ofs,
   input logic rx_valid
);

   a_r2_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo != $past(sdo)) |-> ($rose(sclk) || !$past(port_en)));

   a_r4_sync_drops_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ofs) |-> ($rose(sclk) || !$past(port_en)));

   a_r4_sync_slot_undriven: assert property (@(posedge clk) disable iff (!rst_n)
      ofs |-> !sdo_oe);

   a_r5_clock_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> !sclk);

   a_r7_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $fell(sclk));

   a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

bind fsync_codec_port fcp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .port_en(port_en), .sclk(sclk), .sdo(sdo),
   .sdo_oe(sdo_oe), .ofs(ofs), .rx_valid(rx_valid)
);

// File: tb/tb_fsync_codec_port.sv
module tb_fsync_codec_port;

   logic        clk = 1'b0, rst_n = 1'b0, port_en = 1'b0, sample_tick = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        sdi = 1'b0, ifs = 1'b0;
   logic        sclk, sdo, sdo_oe, ofs, ofs_oe, rx_valid;
   logic [15:0] rx_word;

   fsync_codec_port dut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .sample_tick(sample_tick),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sdi(sdi), .ifs(ifs), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe),
      .ofs(ofs), .ofs_oe(ofs_oe), .rx_word(rx_word), .rx_valid(rx_valid)
   );

   always #10 clk = ~clk;

   int n_checks = 0, n_fail = 0, off_edge = 0;
   logic [15:0] exp_tx[$];
   logic [15:0] exp_rx[$];
   logic [15:0] model_w [6];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- monitor ----------------
   int          mstate = 0;
   logic [15:0] acc = '0;
   bit          bad_oe = 0, bad_fs = 0, rise_now = 0, prev_sclk = 0;
   logic        last_sdo = 0, last_ofs = 0, last_en = 0;

   always @(negedge clk) begin
      rise_now = sclk && !prev_sclk;
      if (rst_n && port_en && last_en && !rise_now && (sdo !== last_sdo || ofs !== last_ofs))
         off_edge++;
      prev_sclk = sclk; last_sdo = sdo; last_ofs = ofs; last_en = port_en;
      if (!rst_n || !port_en) begin
         mstate = 0;
      end else if (rise_now) begin
         if (mstate > 0) begin
            if (mstate == 1 && ofs) bad_fs = 1;
            if (!sdo_oe) bad_oe = 1;
            acc = {acc[14:0], sdo};
            mstate++;
            if (mstate == 17) begin
               mstate = 0;
               if (exp_tx.size() == 0)
                  chk(0, "R3 unexpected word", {16'h0, acc}, 32'h0);
               else begin
                  logic [15:0] e;
                  e = exp_tx.pop_front();
                  chk(acc == e, "R3 word order/bits", {16'h0, acc}, {16'h0, e});
                  chk(!bad_oe && !bad_fs, "R4 sync lead and data enable", {30'h0, bad_fs, bad_oe}, 32'h0);
               end
            end
         end else if (ofs) begin
            bad_fs = sdo_oe;
            bad_oe = 0;
            mstate = 1;
         end
      end
      if (rst_n && rx_valid) begin
         if (exp_rx.size() == 0)
            chk(0, "R7 unexpected strobe", {16'h0, rx_word}, 32'h0);
         else begin
            logic [15:0] e;
            e = exp_rx.pop_front();
            chk(rx_word == e, "R7 received word", {16'h0, rx_word}, {16'h0, e});
         end
      end
   end

   // ---------------- driver tasks ----------------
   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 0;
      if (a < 6) model_w[a] = d;
   endtask

   task automatic start_frame();
      for (int i = 0; i < 6; i++) exp_tx.push_back(model_w[i]);
      @(negedge clk);
      sample_tick = 1;
      @(negedge clk);
      sample_tick = 0;
   endtask

   task automatic wait_rise();
      logic p;
      p = sclk;
      forever begin
         @(negedge clk);
         if (sclk && !p) break;
         p = sclk;
      end
   endtask

   task automatic wait_tx_done();
      while (exp_tx.size() != 0) @(negedge clk);
      repeat (4) wait_rise();
   endtask

   task automatic measure_period(input string tag, input int exp);
      int n;
      logic p;
      wait_rise();
      n = 0; p = sclk;
      forever begin
         @(negedge clk);
         n++;
         if (sclk && !p) break;
         p = sclk;
      end
      chk(n == exp, tag, n, exp);
   endtask

   task automatic send_rx(input logic [15:0] w);
      exp_rx.push_back(w);
      wait_rise();
      ifs = 1;
      wait_rise();
      ifs = 0;
      for (int i = 15; i >= 0; i--) begin
         sdi = w[i];
         wait_rise();
      end
      sdi = 0;
      repeat (2) wait_rise();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      int bad;
      for (int i = 0; i < 6; i++) model_w[i] = '0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(sclk == 0 && sdo_oe == 0 && rx_valid == 0, "R8 outputs in reset",
          {29'h0, sclk, sdo_oe, rx_valid}, 32'h0);
      chk(rx_word == 16'h0, "R8 rx_word in reset", {16'h0, rx_word}, 32'h0);
      rst_n = 1;
      @(negedge clk);
      port_en = 1;
      // R1: cleared dividers act as 1 -> period 2
      measure_period("R1 default period", 2);

      wr(0, 16'hA5C3); wr(1, 16'h0001); wr(2, 16'h8000);
      wr(3, 16'hFFFF); wr(4, 16'h1234); wr(5, 16'h5A5A);
      start_frame();
      wait_tx_done();
      chk(sdo_oe == 0, "R3 idle after frame", {31'h0, sdo_oe}, 32'h0);

      // R1: M=2, S=3 -> period 12
      wr(6, 16'h0002); wr(7, 16'h0003);
      measure_period("R1 period 2*M*S", 12);
      wr(0, 16'h0F0F); wr(1, 16'hF0F0); wr(2, 16'h7FFE);
      wr(3, 16'h0000); wr(4, 16'hC001); wr(5, 16'h3C3C);
      start_frame();
      wait_tx_done();

      // R7: receive path
      send_rx(16'hC3A5);
      send_rx(16'h0F01);
      chk(exp_rx.size() == 0, "R7 all words strobed", exp_rx.size(), 0);

      // R9: second tick while busy queues a second frame
      start_frame();
      repeat (20) @(negedge clk);
      start_frame();
      wait_tx_done();
      chk(exp_tx.size() == 0, "R9 both frames sent", exp_tx.size(), 0);

      // R5/R6: disable in mid-frame
      start_frame();
      repeat (30) wait_rise();
      @(negedge clk);
      port_en = 0;
      exp_tx.delete();
      bad = 0;
      for (int i = 0; i < 60; i++) begin
         ifs = i[0]; sdi = i[1];
         @(negedge clk);
         if (sclk || sdo_oe || ofs_oe || rx_valid) bad++;
      end
      ifs = 0; sdi = 0;
      chk(bad == 0, "R5 quiet while disabled", bad, 0);
      port_en = 1;
      @(negedge clk);
      chk(rx_word == 16'h0F01, "R6 rx_word retained", {16'h0, rx_word}, {16'h0, 16'h0F01});
      measure_period("R6 dividers retained", 12);
      start_frame();
      wait_tx_done();
      chk(exp_rx.size() == 0, "R5 no stray receive", exp_rx.size(), 0);

      chk(off_edge == 0, "R2 transitions only on rising sclk", off_edge, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule